// File: doc/BRIEF.md
# Shared-Medium Transmit Access Controller

This block decides when a station may drive a shared half-duplex line. A frame source raises a request and holds it. The block starts sending only in a cycle where the carrier-sense input shows the line as quiet. If a collision is reported while sending, transmission stops at once. The block then holds a jam indication for a fixed number of bit times and backs off for a random number of whole collision slots before it tries again.

Each collision on the same frame widens the random range by a factor of two, up to a cap. After a set number of collisions in a row the frame is abandoned. A clean finish is reported with a one-cycle done pulse. There is no central arbiter: each station decides from what it senses itself.

All bit-time counting advances only on a one-cycle bit-tick enable, so the block can run from a system clock faster than the line rate. Randomness comes from an internal shift-register generator that steps on every clock after reset.

Top module: `csma_tx_access`

## Requirements
- R1: During and right after reset, tx_en, jam_out, tx_done and tx_abort are all low, the block is idle, and the collision count is zero.
- R2: From idle, tx_en goes high in the cycle after a clock edge that sees frame_req high and carrier_sense low. While carrier_sense is high, the block stays idle.
- R3: A collision sampled while tx_en is high drops tx_en and raises jam_out at the next edge. jam_out then stays high for exactly JAM_BITS bit ticks.
- R4: If collision and frame_end are high in the same transmit cycle, the collision wins. The block jams and gives no done pulse.
- R5: frame_end sampled while transmitting, without a collision, ends the frame. tx_en drops, tx_done is high for exactly the next cycle, and the collision count goes back to zero.
- R6: The random source is a 16-bit register loaded with LFSR_SEED at reset. On every clock it becomes {r[14:0], r[15]^r[13]^r[12]^r[10]}. When the jam after the k-th collision ends, the slot count is r[BACKOFF_CAP-1:0] masked to its low min(k, BACKOFF_CAP) bits, where r is the register value in that cycle. A count of zero returns to idle at that edge.
- R7: A non-zero slot count n keeps the block in backoff for exactly n × SLOT_BITS bit ticks. It then returns to idle, where R2 decides the retry.
- R8: When the jam after collision number MAX_ATTEMPTS ends, tx_abort pulses for one cycle. The block returns to idle with no backoff and clears the collision count.
- R9: collision has no effect unless the block is transmitting. carrier_sense has no effect once transmission has started.
- R10: The jam and backoff counters advance only on edges where bit_tick is high. With bit_tick held low, jam_out holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per line bit time |
| frame_req | input | 1 | Frame waiting to be sent; held until done or abort |
| frame_end | input | 1 | Last bit of the frame is being sent |
| carrier_sense | input | 1 | Another station is active on the line |
| collision | input | 1 | Collision seen on the line |
| tx_en | output | 1 | Drive the frame onto the line |
| jam_out | output | 1 | Send the jam pattern |
| tx_done | output | 1 | One-cycle pulse: frame sent without collision |
| tx_abort | output | 1 | One-cycle pulse: frame abandoned after too many collisions |

## Verification
A collision and the frame's last bit can arrive in the same transmit cycle. The bench drives frame_end and collision together at one negative edge. It then expects jam_out high and tx_done low one cycle later, so the collision path wins. A jam that ends on the final permitted collision is the second meeting point: the abort pulse and the backoff draw compete at the same edge. The bench drives sixteen collisions on one frame and expects exactly one abort and no further backoff. A behavioural reference model, including its own copy of the random sequence from R6, is compared with the outputs on every clock.

// File: rtl/csma_pkg.sv
// Shared types for the transmit access controller.
// Assumes: nothing beyond the standard language.
package csma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_XMIT    = 2'd1,
        ST_JAM     = 2'd2,
        ST_BACKOFF = 2'd3
    } csma_state_e;

    localparam int RNG_W = 16;
endpackage

// File: rtl/csma_lfsr.sv
// Free-running 16-bit Fibonacci shift-register generator.
// It steps on every clock after reset and exposes its low OUT_W bits.
// Assumes: SEED is non-zero and OUT_W <= 16.
module csma_lfsr #(
    parameter int          OUT_W = 10,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    import csma_pkg::*;

    logic [RNG_W-1:0] state_q;
    logic             fb;

    // feedback taps at bits 15, 13, 12 and 10
    always_comb fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

    // advance the sequence once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[RNG_W-2:0], fb};
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/csma_tick_div.sv
// Counts bit ticks modulo LIMIT and flags the tick that closes a span.
// The count is held at zero while clr is high.
// Assumes: LIMIT >= 2.
module csma_tick_div #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic wrap
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // span-closing tick
    always_comb wrap = tick && !clr && (cnt_q == LAST);

    // modulo tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (tick)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/csma_backoff_draw.sv
// Masks a random word down to the binary exponential range for attempt k.
// Bit i survives when k > i, which keeps min(k, CAP) low bits.
// Assumes: attempts holds the collision count including the latest one.
module csma_backoff_draw #(
    parameter int CAP = 10,
    parameter int AW  = 5
) (
    input  logic [AW-1:0]  attempts,
    input  logic [CAP-1:0] rnd,
    output logic [CAP-1:0] slots
);
    for (genvar i = 0; i < CAP; i++) begin : g_bit
        // keep this bit only once the range has grown past it
        always_comb slots[i] = rnd[i] & (int'(attempts) > i);
    end
endmodule

// File: rtl/csma_tx_access.sv
// Transmit access controller for a shared half-duplex line.
// It defers on carrier, stops on collision, jams, then backs off a random
// number of whole slots, and aborts after MAX_ATTEMPTS collisions.
// Assumes: frame_req is held until tx_done or tx_abort, frame_end is pulsed
// by the serializer only while tx_en is high, and BACKOFF_CAP <= 16.
module csma_tx_access #(
    parameter int          SLOT_BITS    = 512,
    parameter int          JAM_BITS     = 32,
    parameter int          MAX_ATTEMPTS = 16,
    parameter int          BACKOFF_CAP  = 10,
    parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_req,
    input  logic frame_end,
    input  logic carrier_sense,
    input  logic collision,
    output logic tx_en,
    output logic jam_out,
    output logic tx_done,
    output logic tx_abort
);
    import csma_pkg::*;

    localparam int AW = $clog2(MAX_ATTEMPTS + 1);
    localparam int SW = BACKOFF_CAP;
    localparam logic [AW-1:0] ATT_MAX = AW'(MAX_ATTEMPTS);

    csma_state_e   st_q;
    logic [AW-1:0] attempts_q;
    logic [SW-1:0] slots_left_q;
    logic [SW-1:0] rnd;
    logic [SW-1:0] draw;
    logic          jam_wrap;
    logic          slot_wrap;
    logic          done_q;
    logic          abort_q;

    csma_lfsr #(.OUT_W(SW), .SEED(LFSR_SEED)) u_rng (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    csma_tick_div #(.LIMIT(JAM_BITS)) u_jam_div (
        .clk(clk), .rst_n(rst_n), .clr(st_q != ST_JAM),
        .tick(bit_tick), .wrap(jam_wrap)
    );

    csma_tick_div #(.LIMIT(SLOT_BITS)) u_slot_div (
        .clk(clk), .rst_n(rst_n), .clr(st_q != ST_BACKOFF),
        .tick(bit_tick), .wrap(slot_wrap)
    );

    csma_backoff_draw #(.CAP(SW), .AW(AW)) u_draw (
        .attempts(attempts_q), .rnd(rnd), .slots(draw)
    );

    // access sequencing, attempt counting and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            attempts_q   <= '0;
            slots_left_q <= '0;
            done_q       <= 1'b0;
            abort_q      <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (frame_req && !carrier_sense) st_q <= ST_XMIT;
                end
                ST_XMIT: begin
                    if (collision) begin
                        st_q       <= ST_JAM;
                        attempts_q <= attempts_q + 1'b1;
                    end else if (frame_end) begin
                        st_q       <= ST_IDLE;
                        done_q     <= 1'b1;
                        attempts_q <= '0;
                    end
                end
                ST_JAM: begin
                    if (jam_wrap) begin
                        if (attempts_q == ATT_MAX) begin
                            st_q       <= ST_IDLE;
                            abort_q    <= 1'b1;
                            attempts_q <= '0;
                        end else if (draw == '0) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q         <= ST_BACKOFF;
                            slots_left_q <= draw;
                        end
                    end
                end
                default: begin
                    if (slot_wrap) begin
                        if (slots_left_q == SW'(1)) st_q <= ST_IDLE;
                        else slots_left_q <= slots_left_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign tx_en    = (st_q == ST_XMIT);
    assign jam_out  = (st_q == ST_JAM);
    assign tx_done  = done_q;
    assign tx_abort = abort_q;

    // R2
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> !$past(carrier_sense));

    // R2
    defer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && carrier_sense) |=> !tx_en);

    // R3
    stop_on_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && collision) |=> (jam_out && !tx_en));

    // R4
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> ($past(tx_en) && $past(frame_end) && !$past(collision)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R8
    abort_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> ($past(jam_out) && !tx_done));

    // R8
    attempts_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempts_q <= ATT_MAX);

    // R10
    jam_end_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jam_out) |-> $past(bit_tick));
endmodule

// File: tb/csma_tx_access_tb.sv
// Bench: behavioural reference model compared with the outputs every clock,
// plus directed checks for the corner cases.
module csma_tx_access_tb_top;
    localparam int S    = 4;
    localparam int J    = 4;
    localparam int MAXA = 16;
    localparam int CAP  = 10;
    localparam int SEED = 16'hACE1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic frame_req = 1'b0;
    logic frame_end = 1'b0;
    logic carrier_sense = 1'b0;
    logic collision = 1'b0;
    logic tx_en, jam_out, tx_done, tx_abort;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int aborts = 0;
    bit tick_en = 1'b1;

    always #5 clk = ~clk;

    csma_tx_access #(.SLOT_BITS(S), .JAM_BITS(J), .MAX_ATTEMPTS(MAXA),
                     .BACKOFF_CAP(CAP), .LFSR_SEED(16'hACE1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_req(frame_req),
        .frame_end(frame_end), .carrier_sense(carrier_sense),
        .collision(collision), .tx_en(tx_en), .jam_out(jam_out),
        .tx_done(tx_done), .tx_abort(tx_abort)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: 0 idle, 1 send, 2 jam, 3 backoff
    int m_st = 0, m_prev = 0, m_att = 0, m_jc = 0, m_bc = 0, m_slots = 0;
    int m_lfsr = SEED;
    bit m_done = 0, m_abort = 0;

    always @(posedge clk) begin
        int fb, draw, k;
        m_prev = m_st;
        if (!rst_n) begin
            m_st = 0; m_att = 0; m_jc = 0; m_bc = 0; m_slots = 0;
            m_lfsr = SEED; m_done = 0; m_abort = 0;
        end else begin
            m_done = 0; m_abort = 0;
            k = (m_att < CAP) ? m_att : CAP;
            draw = m_lfsr & ((1 << k) - 1);
            case (m_st)
                0: if (frame_req && !carrier_sense) m_st = 1;
                1: if (collision) begin m_st = 2; m_att++; m_jc = 0; end
                   else if (frame_end) begin m_st = 0; m_done = 1; m_att = 0; end
                2: if (bit_tick) begin
                       if (m_jc == J - 1) begin
                           if (m_att == MAXA) begin m_st = 0; m_abort = 1; m_att = 0; end
                           else if (draw == 0) m_st = 0;
                           else begin m_st = 3; m_slots = draw; m_bc = 0; end
                       end else m_jc++;
                   end
                default: if (bit_tick) begin
                       if (m_bc == S - 1) begin
                           m_bc = 0;
                           if (m_slots == 1) m_st = 0; else m_slots--;
                       end else m_bc++;
                   end
            endcase
            fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
            m_lfsr = ((m_lfsr << 1) & 16'hFFFF) | fb;
        end
    end

    // tick pattern and per-clock comparison
    always @(negedge clk) begin
        string t;
        cyc++;
        bit_tick <= tick_en && (cyc % 3 != 2);
        if (tx_abort) aborts++;
        if (rst_n) begin
            t = (m_prev == 3) ? "R7 retry timing" : (m_prev == 2) ? "R6 draw" :
                (m_prev == 1) ? "R4 stop" : "R2 start";
            chk(t, int'(tx_en), int'(m_st == 1));
            chk("R3 jam", int'(jam_out), int'(m_st == 2));
            chk("R5 done", int'(tx_done), int'(m_done));
            chk("R8 abort", int'(tx_abort), int'(m_abort));
        end
        if (cyc > 190000) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic wait_xmit();
        while (m_st != 1) @(negedge clk);
    endtask

    task automatic collide();
        @(negedge clk); collision = 1'b1;
        @(negedge clk); collision = 1'b0;
    endtask

    task automatic finish_frame();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0; frame_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 tx_en", int'(tx_en), 0);
        chk("R1 jam", int'(jam_out), 0);
        chk("R1 done", int'(tx_done), 0);
        chk("R1 abort", int'(tx_abort), 0);
        rst_n = 1'b1;

        // R2: defer while busy, then send cleanly
        carrier_sense = 1'b1; frame_req = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 defer", int'(tx_en), 0);
        carrier_sense = 1'b0;
        wait_xmit();
        repeat (5) @(negedge clk);
        finish_frame();
        repeat (4) @(negedge clk);

        // R3/R6/R7: one collision, backoff, retry
        frame_req = 1'b1;
        wait_xmit();
        repeat (3) @(negedge clk);
        collide();
        chk("R3 jam after collision", int'(jam_out), 1);
        wait_xmit();
        finish_frame();
        repeat (4) @(negedge clk);

        // R4: collision and last bit together
        frame_req = 1'b1;
        wait_xmit();
        @(negedge clk); collision = 1'b1; frame_end = 1'b1;
        @(negedge clk); collision = 1'b0; frame_end = 1'b0;
        chk("R4 jam wins", int'(jam_out), 1);
        chk("R4 no done", int'(tx_done), 0);
        // R10: jam frozen without ticks
        tick_en = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 jam holds", int'(jam_out), 1);
        tick_en = 1'b1;
        wait_xmit();
        finish_frame();
        repeat (4) @(negedge clk);

        // R9: stray collision while idle, carrier while sending
        collision = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 idle collision tx", int'(tx_en), 0);
        chk("R9 idle collision jam", int'(jam_out), 0);
        collision = 1'b0;
        frame_req = 1'b1;
        wait_xmit();
        carrier_sense = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 carrier ignored", int'(tx_en), 1);
        carrier_sense = 1'b0;
        finish_frame();
        repeat (4) @(negedge clk);

        // R8: give up after the last permitted collision
        aborts = 0;
        frame_req = 1'b1;
        for (int n = 0; n < MAXA; n++) begin
            wait_xmit();
            @(negedge clk);
            collide();
        end
        frame_req = 1'b0;
        repeat (3 * J + 10) @(negedge clk);
        chk("R8 one abort", aborts, 1);
        chk("R8 idle after abort", int'(tx_en | jam_out), 0);

        // R5: count cleared, next frame starts fresh
        frame_req = 1'b1;
        wait_xmit();
        collide();
        wait_xmit();
        finish_frame();
        repeat (6) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule